// File: doc/BRIEF.md
# Inrush-limited load switch-on sequencer

This block controls the order in which two high-side switches on a battery load path are closed. The first switch carries a series resistor and charges the load capacitance slowly. The second switch is the full-current path. When the load path is requested and the soft-start option is enabled, the block closes the resistive switch first. It hands over to the main switch when a programmable time has passed, or when the measured load voltage has come close enough to the stack voltage. Either exit can be switched off with a zero code. The voltage test is taken only on a coarse sample grid.

The block also handles off requests. An off request opens both switches and returns the sequencer to idle. When the soft-start option is on, an off request also raises a flag that keeps the device out of sleep. If the device is already asleep, the block sends a one-cycle wake pulse. The flag stays set until the host sends a release pulse or a protection fault is reported. Time is counted with an external 1 ms strobe. Voltages arrive as unsigned millivolt readings.

Top module: `inrush_seq`

## Requirements
- R1: With soft-start enabled (`soft_en`=1), a load request closes the resistive switch (`res_sw`=1) at least one clock before the main switch (`main_sw`) closes.
- R2: On the clock edge that ends soft-start, `main_sw` goes to 1 and `res_sw` goes to 0. The two switches are never closed together. `res_status` always equals `res_sw`.
- R3: For a time code T in 1..255, the timeout exit fires on the T*10-th `tick_ms` strobe counted after entry. T=0 disables the timeout exit.
- R4: For a delta code D in 1..255, the load counts as "close" when `load_mv` >= `stack_mv` or when `stack_mv`-`load_mv` <= D*10. This test is made only on every 250th `tick_ms` strobe after entry. D=0 disables the voltage exit.
- R5: When both exits are enabled, soft-start ends on whichever exit fires first.
- R6: With both codes 0 and soft-start enabled, the resistive switch stays closed for exactly one clock and the main switch then closes.
- R7: With soft-start disabled, a request closes `main_sw` on the next edge and never closes `res_sw`.
- R8: Dropping `load_req`, or asserting `off_main` or `off_all`, opens both switches on the next edge. While either off input is held, a request closes nothing.
- R9: A rising edge of (`off_main` | `off_all`) while `soft_en`=1 sets `sleep_blk`. With `soft_en`=0 it does not set it.
- R10: When R9 sets `sleep_blk` while `asleep`=1, `wake_req` is high for exactly one clock.
- R11: `sleep_blk` clears after a `host_rel` pulse or any set bit of `fault`. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-clock strobe every millisecond |
| load_req | input | 1 | Request to power the load |
| soft_en | input | 1 | Enable the resistive soft-start phase |
| time_code | input | 8 | Timeout code, 10 ms per step, 0 = off |
| delta_code | input | 8 | Voltage delta code, 10 mV per step, 0 = off |
| stack_mv | input | 16 | Stack voltage in mV |
| load_mv | input | 16 | Load voltage in mV |
| off_main | input | 1 | Main-path off request |
| off_all | input | 1 | All-switches off request |
| host_rel | input | 1 | Host pulse releasing the sleep block |
| fault | input | 3 | Protection fault flags |
| asleep | input | 1 | Device currently in sleep |
| res_sw | output | 1 | Resistive soft-start switch enable |
| main_sw | output | 1 | Main switch enable |
| res_status | output | 1 | Resistive switch state for status |
| sleep_blk | output | 1 | Sleep inhibit flag |
| wake_req | output | 1 | One-clock request to leave sleep |

## Verification
Two pairs of functions can fall on the same cycle. The first pair is the timeout exit and the 250 ms voltage sample. The bench provokes them with time codes just below, at and above 25, under a load voltage that passes or just fails the delta test. The observed strobe count at handover is then compared with the earlier of the two exits. The second pair is a fresh off request and a release pulse, driven on the same edge. The bench expects `sleep_blk` to stay set and to clear only on a later release.

// File: rtl/inrush_pkg.sv
// Shared types for the inrush-limited switch-on sequencer.
package inrush_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOFT = 2'd1,
        ST_MAIN = 2'd2
    } seq_st_t;
endpackage

// File: rtl/inrush_timer.sv
// Elapsed-time tracker for the soft-start phase.
// Counts millisecond strobes while run is high, and clears while run is low.
// This makes each entry start from zero.
// Assumes tick is a single-clock strobe.
module inrush_timer #(
    parameter int CODE_W     = 8,
    parameter int MS_PER_LSB = 10,
    parameter int SAMPLE_MS  = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [CODE_W-1:0] time_code,
    output logic              tmo_due,
    output logic              smp_due
);
    localparam int LIM_W = $clog2((2**CODE_W - 1) * MS_PER_LSB + 1);
    localparam int SMP_W = $clog2(SAMPLE_MS);
    localparam logic [LIM_W-1:0] MS_MAX   = '1;
    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_MS - 1);

    logic [LIM_W-1:0] ms_cnt;
    logic [SMP_W-1:0] smp_cnt;
    logic [LIM_W:0]   limit;
    logic [LIM_W:0]   ms_next;

    // Threshold and next count, widened by one bit so the compare cannot wrap.
    always_comb begin
        limit   = (LIM_W+1)'(time_code) * (LIM_W+1)'(MS_PER_LSB);
        ms_next = {1'b0, ms_cnt} + 1'b1;
        tmo_due = run && tick && (time_code != '0) && (ms_next >= limit);
        smp_due = run && tick && (smp_cnt == SMP_LAST);
    end

    // Count strobes while the phase runs; saturate ms, wrap the sample grid.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ms_cnt  <= '0;
            smp_cnt <= '0;
        end else if (tick) begin
            if (ms_cnt != MS_MAX) ms_cnt <= ms_cnt + 1'b1;
            smp_cnt <= (smp_cnt == SMP_LAST) ? '0 : smp_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/inrush_delta.sv
// Voltage closeness test for the soft-start exit.
// Reports whether the load is at or above the stack, or within the coded delta below it.
// Purely combinational; the caller decides when the result counts.
module inrush_delta #(
    parameter int CODE_W     = 8,
    parameter int MV_W       = 16,
    parameter int MV_PER_LSB = 10
) (
    input  logic [MV_W-1:0]   stack_mv,
    input  logic [MV_W-1:0]   load_mv,
    input  logic [CODE_W-1:0] delta_code,
    output logic              close
);
    localparam int DL_W = $clog2((2**CODE_W - 1) * MV_PER_LSB + 1);
    localparam int CW   = (MV_W > DL_W) ? MV_W : DL_W;

    logic [CW-1:0] gap;
    logic [CW-1:0] thr;

    // Gap below the stack against the programmed window.
    always_comb begin
        gap   = CW'(stack_mv - load_mv);
        thr   = CW'(delta_code) * CW'(MV_PER_LSB);
        close = (load_mv >= stack_mv) || (gap <= thr);
    end
endmodule

// File: rtl/inrush_fsm.sv
// Switch sequencing state machine: idle, soft-start, main.
// Switch enables are decoded from the state register only, so they are glitch-free.
// Off requests and a dropped request take priority over every exit.
module inrush_fsm
    import inrush_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic soft_en,
    input  logic off,
    input  logic tmo_en,
    input  logic dlt_en,
    input  logic tmo_due,
    input  logic smp_due,
    input  logic close,
    output logic run,
    output logic res_sw,
    output logic main_sw
);
    seq_st_t st, st_nx;
    logic    leave;

    // Exit decision for the soft-start phase.
    always_comb begin
        leave = (!tmo_en && !dlt_en)
              || tmo_due
              || (dlt_en && smp_due && close);
    end

    // Next-state logic.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (req && !off) st_nx = soft_en ? ST_SOFT : ST_MAIN;
            ST_SOFT: if (!req || off) st_nx = ST_IDLE;
                     else if (leave)  st_nx = ST_MAIN;
            ST_MAIN: if (!req || off) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    assign run     = (st == ST_SOFT);
    assign res_sw  = (st == ST_SOFT);
    assign main_sw = (st == ST_MAIN);
endmodule

// File: rtl/inrush_sleep.sv
// Sleep-inhibit flag and wake pulse.
// The flag is set on a fresh off request when soft-start is enabled.
// It is released by a host pulse or any fault; the set wins a same-cycle tie.
module inrush_sleep #(
    parameter int N_FLT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off,
    input  logic             soft_en,
    input  logic             asleep,
    input  logic             host_rel,
    input  logic [N_FLT-1:0] fault,
    output logic             sleep_blk,
    output logic             wake_req
);
    logic off_q;
    logic arm;
    logic rel;

    // Edge detect and release decode.
    always_comb begin
        arm = off && !off_q && soft_en;
        rel = host_rel || (|fault);
    end

    // Flag, wake pulse and off history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q     <= 1'b0;
            sleep_blk <= 1'b0;
            wake_req  <= 1'b0;
        end else begin
            off_q    <= off;
            wake_req <= arm && asleep;
            if (arm)      sleep_blk <= 1'b1;
            else if (rel) sleep_blk <= 1'b0;
        end
    end
endmodule

// File: rtl/inrush_seq.sv
// Top of the inrush-limited switch-on sequencer.
// Wires the timer, voltage test, state machine and sleep guard together.
// Assumes tick_ms is one clock wide and voltage readings are already synchronous.
module inrush_seq #(
    parameter int CODE_W     = 8,
    parameter int MV_W       = 16,
    parameter int MS_PER_LSB = 10,
    parameter int MV_PER_LSB = 10,
    parameter int SAMPLE_MS  = 250,
    parameter int N_FLT      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              load_req,
    input  logic              soft_en,
    input  logic [CODE_W-1:0] time_code,
    input  logic [CODE_W-1:0] delta_code,
    input  logic [MV_W-1:0]   stack_mv,
    input  logic [MV_W-1:0]   load_mv,
    input  logic              off_main,
    input  logic              off_all,
    input  logic              host_rel,
    input  logic [N_FLT-1:0]  fault,
    input  logic              asleep,
    output logic              res_sw,
    output logic              main_sw,
    output logic              res_status,
    output logic              sleep_blk,
    output logic              wake_req
);
    logic off, run, tmo_due, smp_due, close;

    assign off = off_main | off_all;

    inrush_timer #(.CODE_W(CODE_W), .MS_PER_LSB(MS_PER_LSB), .SAMPLE_MS(SAMPLE_MS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_ms),
        .time_code(time_code), .tmo_due(tmo_due), .smp_due(smp_due)
    );

    inrush_delta #(.CODE_W(CODE_W), .MV_W(MV_W), .MV_PER_LSB(MV_PER_LSB)) u_dlt (
        .stack_mv(stack_mv), .load_mv(load_mv), .delta_code(delta_code), .close(close)
    );

    inrush_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(load_req), .soft_en(soft_en), .off(off),
        .tmo_en(time_code != '0), .dlt_en(delta_code != '0),
        .tmo_due(tmo_due), .smp_due(smp_due), .close(close),
        .run(run), .res_sw(res_sw), .main_sw(main_sw)
    );

    inrush_sleep #(.N_FLT(N_FLT)) u_slp (
        .clk(clk), .rst_n(rst_n), .off(off), .soft_en(soft_en), .asleep(asleep),
        .host_rel(host_rel), .fault(fault), .sleep_blk(sleep_blk), .wake_req(wake_req)
    );

    assign res_status = res_sw;
endmodule

// File: rtl/inrush_seq_chk.sv
// Property checker for inrush_seq, attached through bind.
// Observes ports only.
module inrush_seq_chk #(
    parameter int CODE_W = 8,
    parameter int N_FLT  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_req,
    input logic              soft_en,
    input logic [CODE_W-1:0] time_code,
    input logic [CODE_W-1:0] delta_code,
    input logic              off_main,
    input logic              off_all,
    input logic              host_rel,
    input logic [N_FLT-1:0]  fault,
    input logic              asleep,
    input logic              res_sw,
    input logic              main_sw,
    input logic              sleep_blk,
    input logic              wake_req
);
    logic off;
    assign off = off_main | off_all;

    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_sw && main_sw));

    p_soft_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(main_sw) && $past(soft_en)) |-> $past(res_sw));

    p_off_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (off || !load_req) |=> (!res_sw && !main_sw));

    p_zero_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sw && load_req && !off && time_code == '0 && delta_code == '0) |=> main_sw);

    p_block_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(off) && soft_en) |=> sleep_blk);

    p_block_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rel || (|fault)) && !($rose(off) && soft_en)) |=> !sleep_blk);

    p_wake_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ($past(asleep) && sleep_blk));
endmodule

bind inrush_seq inrush_seq_chk #(.CODE_W(CODE_W), .N_FLT(N_FLT)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .soft_en(soft_en),
    .time_code(time_code), .delta_code(delta_code), .off_main(off_main),
    .off_all(off_all), .host_rel(host_rel), .fault(fault), .asleep(asleep),
    .res_sw(res_sw), .main_sw(main_sw), .sleep_blk(sleep_blk), .wake_req(wake_req)
);

// File: tb/sim_inrush_seq.sv
module sim_inrush_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        load_req = 1'b0;
    logic        soft_en = 1'b0;
    logic [7:0]  time_code = '0;
    logic [7:0]  delta_code = '0;
    logic [15:0] stack_mv = '0;
    logic [15:0] load_mv = '0;
    logic        off_main = 1'b0;
    logic        off_all = 1'b0;
    logic        host_rel = 1'b0;
    logic [2:0]  fault = '0;
    logic        asleep = 1'b0;
    logic        res_sw, main_sw, res_status, sleep_blk, wake_req;

    int errors = 0;
    int checks = 0;
    int wakes  = 0;
    int cycles = 0;
    int tk     = 0;
    int tick_div = 0;
    logic [1:0] last_sw = 2'b00;

    typedef struct {
        logic  res;
        logic  main;
        int    ticks;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    inrush_seq u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .load_req(load_req),
        .soft_en(soft_en), .time_code(time_code), .delta_code(delta_code),
        .stack_mv(stack_mv), .load_mv(load_mv), .off_main(off_main),
        .off_all(off_all), .host_rel(host_rel), .fault(fault), .asleep(asleep),
        .res_sw(res_sw), .main_sw(main_sw), .res_status(res_status),
        .sleep_blk(sleep_blk), .wake_req(wake_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic r, input logic m, input int t, input string tag);
        exp_t e;
        e.res = r; e.main = m; e.ticks = t; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        step(3);
    endtask

    // Millisecond strobe, one clock in four, driven just after the edge.
    initial forever begin
        @(posedge clk); #1;
        tick_ms = (tick_div == 3);
        tick_div = (tick_div + 1) % 4;
    end

    // Monitor: compare every switch transition against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if ({res_sw, main_sw} != last_sw) begin
                if (q.size() == 0) begin
                    chk(1'b0, "unexpected transition R8", {res_sw, main_sw}, last_sw);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(res_sw == e.res && main_sw == e.main, e.tag,
                        {res_sw, main_sw}, {e.res, e.main});
                    chk(res_status == res_sw, "status R2", res_status, res_sw);
                    if (e.ticks >= 0) chk(tk == e.ticks, {e.tag, " ticks"}, tk, e.ticks);
                end
                last_sw = {res_sw, main_sw};
                tk = 0;
            end
            if (tick_ms) tk++;
            if (wake_req) wakes++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic soft_run(input int tc, input int dc, input int exp_ticks, input string tag);
        time_code = 8'(tc); delta_code = 8'(dc);
        push(1, 0, -1, {tag, " soft on first R1"});
        push(0, 1, exp_ticks, {tag, " handover R2"});
        load_req = 1'b1;
        drain();
        push(0, 0, -1, {tag, " drop R8"});
        load_req = 1'b0;
        drain();
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        @(negedge clk);
        chk(!res_sw && !main_sw && !sleep_blk && !wake_req, "reset", {res_sw, main_sw, sleep_blk}, 0);
        step(1);

        // R7: direct switch-on without soft-start.
        soft_en = 1'b0;
        push(0, 1, -1, "direct R7");
        load_req = 1'b1;
        drain();
        push(0, 0, -1, "direct drop R8");
        load_req = 1'b0;
        drain();

        soft_en  = 1'b1;
        stack_mv = 16'd30000;
        load_mv  = 16'd10000;
        soft_run(3, 0, 30, "timeout only R3");
        load_mv = 16'd29000;
        soft_run(20, 100, 200, "timeout before sample R5");
        soft_run(40, 100, 250, "sample before timeout R5 R4");
        soft_run(40, 99, 400, "delta boundary miss R4");
        soft_run(25, 100, 250, "tie timeout and sample R5");
        load_mv = 16'd31000;
        soft_run(0, 5, 250, "load above stack R4");
        soft_run(0, 0, 0, "both codes zero R6");

        // R8: abort during soft-start.
        time_code = 8'd50; delta_code = 8'd0;
        push(1, 0, -1, "abort enter R1");
        push(0, 0, -1, "abort drop R8");
        load_req = 1'b1;
        step(20);
        load_req = 1'b0;
        drain();

        // R9 R10: off request while running, device asleep.
        time_code = 8'd0; delta_code = 8'd0;
        push(1, 0, -1, "off run R1");
        push(0, 1, 0, "off run R6");
        load_req = 1'b1;
        drain();
        asleep = 1'b1;
        wakes  = 0;
        push(0, 0, -1, "off_all opens R8");
        off_all = 1'b1;
        drain();
        chk(sleep_blk == 1'b1, "sleep block set R9", sleep_blk, 1);
        chk(wakes == 1, "single wake pulse R10", wakes, 1);
        step(20);
        chk(!res_sw && !main_sw, "held off keeps idle R8", {res_sw, main_sw}, 0);
        load_req = 1'b0;
        off_all  = 1'b0;
        asleep   = 1'b0;
        step(2);
        fault = 3'b100;
        step(1);
        fault = 3'b000;
        @(negedge clk);
        chk(sleep_blk == 1'b0, "fault release R11", sleep_blk, 0);

        // R11: set and release on the same edge, set wins.
        step(1);
        off_main = 1'b1;
        host_rel = 1'b1;
        step(1);
        host_rel = 1'b0;
        @(negedge clk);
        chk(sleep_blk == 1'b1, "set beats release R11", sleep_blk, 1);
        chk(wakes == 1, "no wake while awake R10", wakes, 1);
        step(2);
        host_rel = 1'b1;
        step(1);
        host_rel = 1'b0;
        @(negedge clk);
        chk(sleep_blk == 1'b0, "host release R11", sleep_blk, 0);
        off_main = 1'b0;
        step(2);

        // R9: no sleep block when soft-start is disabled.
        soft_en = 1'b0;
        off_main = 1'b1;
        step(2);
        @(negedge clk);
        chk(sleep_blk == 1'b0, "no block without soft-start R9", sleep_blk, 0);
        off_main = 1'b0;
        step(4);
        chk(q.size() == 0, "scoreboard empty", q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule